// File: doc/BRIEF.md
# Microsecond Timer with Alarm Channels

This block keeps a 64-bit time base that steps once for each pulse on its tick input. The pulse comes from an outside prescaler that divides a reference clock into microseconds; the system clock only samples the pulse. Software reaches the block through a simple word-wide register bus. It can load the full time coherently, read it coherently, read the low half on its own, pause counting, and program four single-shot compare alarms. Each alarm has its own interrupt line.

A time write is done in two steps. A write to the low staging word only holds the value. A following write to the high word loads the counter with both halves at once. A coherent read works the same way in reverse. Reading the latching low word captures the high half in a small two-state machine, and the next read of the high word returns the captured value. The states are LATCH_OPEN and LATCH_HELD. The transition *capture* (a latching-low read) leads to LATCH_HELD. The transition *release* (a high read) leads back to LATCH_OPEN. In LATCH_OPEN the high word shows the live upper half.

An alarm compares its 32-bit target with the low half of the counter. The upper half plays no part. When the two match on an armed alarm, the alarm fires: it sets a sticky raw-interrupt bit and disarms itself. It stays silent until its target register is written again.

Top module: `usec_timer`

## Requirements
- R1: The counter rises by exactly one at each clock edge where `tick_i` is high, the pause bit is clear and no load occurs. It holds its value on every other edge.
- R2: Bit 0 of the pause word (offset 10) stops the counter while it is set; tick pulses are then lost. Clearing the bit lets counting resume.
- R3: A write to offset 0 only stages a 32-bit value. A write to offset 1 loads the counter with that write's data as the upper half and the staged value as the lower half. A load takes priority over a tick in the same cycle.
- R4: A read of offset 2 returns the live low half and moves the latch machine to LATCH_HELD, holding the upper half. A read of offset 3 returns the held upper half in LATCH_HELD, or the live upper half in LATCH_OPEN, and returns the machine to LATCH_OPEN.
- R5: A read of offset 9 returns the live low half and leaves the latch machine unchanged.
- R6: A write to offset 4+i (i = 0..3) stores the data as alarm i's target and sets bit i of the armed word (offset 8). A read of offset 4+i returns the target.
- R7: An armed alarm whose target equals the counter's low half fires: one edge later its armed bit is clear and its raw-interrupt bit is set. Firing ignores the upper half. A fired alarm does not fire again until it is rewritten.
- R8: Writing offset 8 clears each armed bit written as one, with no firing. Bits written as zero have no effect.
- R9: The raw-interrupt word (offset 11) keeps each fired bit until a one is written to that bit. Zero bits written have no effect. A new firing wins over a clear in the same cycle.
- R10: `irq[i]` equals raw-interrupt bit i ANDed with bit i of the enable word (offset 12).
- R11: A write whose byte enables are not all ones changes no register.
- R12: After reset the counter, staging word, armed bits, raw interrupts, enables and pause bit are zero, and the latch machine is in LATCH_OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle microsecond pulse from the prescaler |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Word offset |
| bus_be | input | 4 | Byte enables; only all-ones writes take effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected, zero otherwise |
| irq | output | 4 | Per-alarm interrupt lines |

## Verification
Some rules are checked by assertions on every cycle. These cover the step-by-one and hold rules of the counter, the load value, and the capture transition of the latch machine. They also cover an alarm disarming itself after it fires, its raw bit being set, and partial writes leaving the enable and pause words untouched. Other behaviour only shows up through the bench's register scenarios. These include the staged time load, reading a held upper half across a carry, firing that ignores the upper half, single-shot behaviour after the counter is reloaded, disarming with no firing, and write-one-to-clear with zero bits written.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
    localparam int OFF_WLO   = 0;
    localparam int OFF_WHI   = 1;
    localparam int OFF_RLO   = 2;
    localparam int OFF_RHI   = 3;
    localparam int OFF_ALARM = 4;
    localparam int OFF_ARMED = 8;
    localparam int OFF_RAWLO = 9;
    localparam int OFF_PAUSE = 10;
    localparam int OFF_IRAW  = 11;
    localparam int OFF_IEN   = 12;

    typedef enum logic {
        LATCH_OPEN = 1'b0,
        LATCH_HELD = 1'b1
    } latch_state_t;
endpackage

// File: rtl/ut_counter.sv
module ut_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pause,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (tick && !pause) cnt <= cnt + CNT_W'(1);
    end

    // R1
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pause && !load) |=> (cnt == $past(cnt) + CNT_W'(1)));
    // R2
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !load) |=> $stable(cnt));
    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/ut_hilatch.sv
module ut_hilatch
    import usec_timer_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [HALF_W-1:0] live_hi,
    output logic [HALF_W-1:0] hi_view
);
    latch_state_t      state_q, state_d;
    logic [HALF_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LATCH_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     held_q <= '0;
        else if (rd_lo) held_q <= live_hi;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LATCH_OPEN: if (rd_lo) state_d = LATCH_HELD;
            LATCH_HELD: if (rd_hi) state_d = LATCH_OPEN;
            default:    state_d = LATCH_OPEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LATCH_HELD: hi_view = held_q;
            default:    hi_view = live_hi;
        endcase
    end

    // R4
    capture_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (state_q == LATCH_HELD));
    // R4
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (hi_view == $past(live_hi)));
endmodule

// File: rtl/ut_alarm.sv
module ut_alarm #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              disarm,
    input  logic [HALF_W-1:0] cnt_lo,
    output logic              armed,
    output logic              fire,
    output logic [HALF_W-1:0] target
);
    assign fire = armed && (cnt_lo == target) && !wr && !disarm;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            target <= '0;
        end else if (wr) begin
            armed  <= 1'b1;
            target <= wdata;
        end else if (disarm || fire) begin
            armed  <= 1'b0;
        end
    end

    // R7
    self_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !armed);
    // R6
    arm_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (armed && target == $past(wdata)));
    // R8
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm && !wr) |=> !armed);
endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import usec_timer_pkg::*;
#(
    parameter int CNT_W      = 64,
    parameter int NUM_ALARMS = 4,
    parameter int ADDR_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CNT_W/16-1:0]   bus_be,
    input  logic [CNT_W/2-1:0]    bus_wdata,
    output logic [CNT_W/2-1:0]    bus_rdata,
    output logic [NUM_ALARMS-1:0] irq
);
    localparam int HALF_W = CNT_W / 2;
    localparam int BE_W   = HALF_W / 8;

    logic                  wr_ok, rd_ok;
    logic [HALF_W-1:0]     staged_q;
    logic                  pause_q;
    logic [NUM_ALARMS-1:0] iraw_q, ien_q, iraw_clr;
    logic [NUM_ALARMS-1:0] alm_wr, alm_disarm, armed, fire;
    logic [HALF_W-1:0]     target [NUM_ALARMS];
    logic [CNT_W-1:0]      cnt;
    logic [HALF_W-1:0]     hi_view;
    logic                  load;

    assign wr_ok = bus_sel && bus_wr && (bus_be == {BE_W{1'b1}});
    assign rd_ok = bus_sel && !bus_wr;
    assign load  = wr_ok && (bus_addr == ADDR_W'(OFF_WHI));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
            pause_q  <= 1'b0;
            ien_q    <= '0;
        end else if (wr_ok) begin
            if (bus_addr == ADDR_W'(OFF_WLO))   staged_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_PAUSE)) pause_q  <= bus_wdata[0];
            if (bus_addr == ADDR_W'(OFF_IEN))   ien_q    <= bus_wdata[NUM_ALARMS-1:0];
        end
    end

    ut_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_i),
        .pause    (pause_q),
        .load     (load),
        .load_val ({bus_wdata, staged_q}),
        .cnt      (cnt)
    );

    ut_hilatch #(.HALF_W(HALF_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_lo   (rd_ok && bus_addr == ADDR_W'(OFF_RLO)),
        .rd_hi   (rd_ok && bus_addr == ADDR_W'(OFF_RHI)),
        .live_hi (cnt[CNT_W-1:HALF_W]),
        .hi_view (hi_view)
    );

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
        assign alm_wr[i]     = wr_ok && (bus_addr == ADDR_W'(OFF_ALARM + i));
        assign alm_disarm[i] = wr_ok && (bus_addr == ADDR_W'(OFF_ARMED)) && bus_wdata[i];
        assign iraw_clr[i]   = wr_ok && (bus_addr == ADDR_W'(OFF_IRAW)) && bus_wdata[i];

        ut_alarm #(.HALF_W(HALF_W)) u_alarm (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (alm_wr[i]),
            .wdata  (bus_wdata),
            .disarm (alm_disarm[i]),
            .cnt_lo (cnt[HALF_W-1:0]),
            .armed  (armed[i]),
            .fire   (fire[i]),
            .target (target[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iraw_q <= '0;
        else        iraw_q <= fire | (iraw_q & ~iraw_clr);
    end

    assign irq = iraw_q & ien_q;

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            if (bus_addr == ADDR_W'(OFF_WLO))   bus_rdata = staged_q;
            if (bus_addr == ADDR_W'(OFF_RLO))   bus_rdata = cnt[HALF_W-1:0];
            if (bus_addr == ADDR_W'(OFF_RHI))   bus_rdata = hi_view;
            if (bus_addr == ADDR_W'(OFF_ARMED)) bus_rdata = HALF_W'(armed);
            if (bus_addr == ADDR_W'(OFF_RAWLO)) bus_rdata = cnt[HALF_W-1:0];
            if (bus_addr == ADDR_W'(OFF_PAUSE)) bus_rdata = HALF_W'(pause_q);
            if (bus_addr == ADDR_W'(OFF_IRAW))  bus_rdata = HALF_W'(iraw_q);
            if (bus_addr == ADDR_W'(OFF_IEN))   bus_rdata = HALF_W'(ien_q);
            for (int k = 0; k < NUM_ALARMS; k++)
                if (bus_addr == ADDR_W'(OFF_ALARM + k)) bus_rdata = target[k];
        end
    end

    // R9
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> ((iraw_q & $past(fire)) == $past(fire)));
    // R11
    partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be != {BE_W{1'b1}}) |=> ($stable(ien_q) && $stable(pause_q)));
endmodule

// File: tb/tb_usec_timer.sv
module tb_usec_timer;
    localparam logic [3:0] A_WLO = 4'd0,  A_WHI = 4'd1,  A_RLO = 4'd2,  A_RHI = 4'd3;
    localparam logic [3:0] A_AL0 = 4'd4,  A_ARM = 4'd8,  A_RAW = 4'd9,  A_PAU = 4'd10;
    localparam logic [3:0] A_IRW = 4'd11, A_IEN = 4'd12;

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;   // write data, or expected read value
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_RAW, 4'hF, 32'h0,         8'd12}, // R12 counter cleared
        '{1'b1, A_WLO, 4'hF, 32'h1111_2222, 8'd3},
        '{1'b0, A_RAW, 4'hF, 32'h0,         8'd3},  // R3 staging alone does not load
        '{1'b1, A_WHI, 4'hF, 32'h5,         8'd3},
        '{1'b0, A_RAW, 4'hF, 32'h1111_2222, 8'd3},  // R3 loaded
        '{1'b0, A_RLO, 4'hF, 32'h1111_2222, 8'd4},  // R4
        '{1'b0, A_RHI, 4'hF, 32'h5,         8'd4},  // R4
        '{1'b1, A_IEN, 4'hF, 32'hF,         8'd10},
        '{1'b0, A_IEN, 4'hF, 32'hF,         8'd10}, // R10
        '{1'b1, A_IEN, 4'h1, 32'h0,         8'd11},
        '{1'b0, A_IEN, 4'hF, 32'hF,         8'd11}, // R11 partial write ignored
        '{1'b1, A_AL0, 4'hF, 32'h100,       8'd6},
        '{1'b0, A_ARM, 4'hF, 32'h1,         8'd6},  // R6 armed
        '{1'b1, A_ARM, 4'hF, 32'h0,         8'd8},
        '{1'b0, A_ARM, 4'hF, 32'h1,         8'd8},  // R8 zeros no effect
        '{1'b1, A_ARM, 4'hF, 32'h1,         8'd8},
        '{1'b0, A_ARM, 4'hF, 32'h0,         8'd8}   // R8 disarmed
    };

    logic        clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0, bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  irq;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    usec_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic set_time(input logic [31:0] hi, input logic [31:0] lo);
        wr(A_WLO, lo, 4'hF);
        wr(A_WHI, hi, 4'hF);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state at the ports
        rd_chk(A_ARM, 32'h0, "R12");
        rd_chk(A_IRW, 32'h0, "R12");
        check("R12", {28'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            if (VECS[i].is_wr) wr(VECS[i].addr, VECS[i].data, VECS[i].be);
            else begin
                rd(VECS[i].addr, v);
                check($sformatf("R%0d row %0d", VECS[i].req, i), v, VECS[i].data);
            end
        end

        // R1 step per tick, hold between pulses
        set_time(32'h0, 32'h0);
        ticks(5);
        repeat (4) @(negedge clk);
        rd_chk(A_RAW, 32'd5, "R1");

        // R4 held upper half across a carry; R5 raw read leaves latch alone
        set_time(32'h2, 32'hFFFF_FFFF);
        rd_chk(A_RLO, 32'hFFFF_FFFF, "R4");
        ticks(1);
        rd_chk(A_RAW, 32'h0, "R5");
        rd_chk(A_RHI, 32'h2, "R4");
        rd_chk(A_RHI, 32'h3, "R4");

        // R2 pause
        set_time(32'h0, 32'd20);
        wr(A_PAU, 32'h1, 4'hF);
        ticks(3);
        rd_chk(A_RAW, 32'd20, "R2");
        wr(A_PAU, 32'h0, 4'hF);
        ticks(1);
        rd_chk(A_RAW, 32'd21, "R2");

        // R7 fire, self disarm, interrupt (enables all set)
        set_time(32'h0, 32'h0);
        wr(A_AL0 + 4'd2, 32'd3, 4'hF);
        rd_chk(A_AL0 + 4'd2, 32'd3, "R6");
        ticks(3);
        rd_chk(A_IRW, 32'h4, "R7");
        rd_chk(A_ARM, 32'h0, "R7");
        check("R10", {28'h0, irq}, 32'h4);
        // R7 single shot after reload
        wr(A_IRW, 32'h4, 4'hF);
        set_time(32'h0, 32'h0);
        ticks(3);
        rd_chk(A_IRW, 32'h0, "R7");

        // R7 upper half ignored; R10 enable gating; R9 W1C
        wr(A_IEN, 32'h0, 4'hF);
        wr(A_AL0 + 4'd1, 32'd10, 4'hF);
        set_time(32'h7, 32'd9);
        ticks(1);
        rd_chk(A_IRW, 32'h2, "R7");
        check("R10", {28'h0, irq}, 32'h0);
        wr(A_IEN, 32'h2, 4'hF);
        check("R10", {28'h0, irq}, 32'h2);
        wr(A_IRW, 32'h0, 4'hF);
        rd_chk(A_IRW, 32'h2, "R9");
        wr(A_IRW, 32'h2, 4'hF);
        rd_chk(A_IRW, 32'h0, "R9");
        check("R9", {28'h0, irq}, 32'h0);

        // R8 disarm without firing
        set_time(32'h0, 32'h0);
        wr(A_AL0 + 4'd3, 32'd2, 4'hF);
        wr(A_ARM, 32'h8, 4'hF);
        ticks(3);
        rd_chk(A_IRW, 32'h0, "R8");

        // R11 partial writes to an alarm and to the time high word
        wr(A_AL0, 32'd50, 4'h3);
        rd_chk(A_ARM, 32'h0, "R11");
        wr(A_WHI, 32'h9, 4'h7);
        rd_chk(A_RAW, 32'd3, "R11");

        summary();
    end
endmodule